// File: doc/BRIEF.md
# Two-Field Record Map Stage

This block carries a stream of records, each made of two equal-width unsigned fields, from a valid/ready input channel to a valid/ready output channel. Each field is applied to its own processing branch, and every branch doubles its field. The block broadcasts every incoming record to both branches. Each branch takes its own field. When both results are present, the block packs them again into one outgoing record of the same layout.

Flow control on each branch is independent. A branch that has already taken its field is remembered, so the field is not handed over twice while the other branch is still stalled. The incoming record is acknowledged only after both branches hold their field. The outgoing record is offered only when both results are available, and one output handshake retires both results. Each branch is built as a registered stage or as a pass-through combinational stage, chosen per branch by a parameter. The default build registers the low field's branch and leaves the high field's branch combinational.

Top module: `tuple_fmap_top`

## Requirements
- R1: A record occupies 2*DW bits. Field 0 sits in bits [DW-1:0] and field 1 in bits [2*DW-1:DW]. Each output field is twice the matching input field, and the output keeps the same layout.
- R2: Doubling wraps modulo 2^DW and the carry out of the top bit is discarded. For example, 16'h8001 becomes 16'h0002 and 16'hFFFF becomes 16'hFFFE.
- R3: While the synchronous active-high reset is high and in the first cycle after it, out_valid is low.
- R4: Every accepted input record produces exactly one output record, in acceptance order. No record is duplicated or dropped, whatever pattern of input gaps and output stalls occurs. No more than one accepted record is ever outstanding.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged in the next cycle.
- R6: In the default build, a record is presented to an idle block whose output is ready. out_valid is low in the cycle of presentation. In the next cycle the result is offered, and in_ready is high in that same cycle, so input and output handshake together.
- R7: While the output is stalled (out_valid high, out_ready low), in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 2*DW | Incoming record, field 1 in the upper half |
| in_valid | input | 1 | Incoming record is present |
| in_ready | output | 1 | Incoming record is taken at this edge |
| out_data | output | 2*DW | Outgoing record, same layout |
| out_valid | output | 1 | Outgoing record is present |
| out_ready | input | 1 | Downstream takes the outgoing record |

## Verification
The bench builds the block with its defaults: DW of 16, a registered branch on field 0 and a combinational branch on field 1. Because the two branch latencies differ, field 0 is taken a cycle before field 1 can be delivered. This makes the per-branch taken flag matter, and a block that handed field 0 over twice would be visible as a duplicated or shifted output record. A 16-bit width makes the wrap of values with the top bit set easy to check directly.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

    localparam int unsigned FIELD_W_DEF = 16;
    localparam int unsigned NUM_BR      = 2;

    typedef enum logic {
        STG_COMB = 1'b0,
        STG_REG  = 1'b1
    } stage_kind_e;

    function automatic logic hs_fire(input logic v, input logic r);
        return v & r;
    endfunction

endpackage

// File: rtl/tfm_fork.sv
module tfm_fork #(
    parameter int unsigned NB = tfm_pkg::NUM_BR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          src_valid,
    output logic          src_ready,
    output logic [NB-1:0] br_valid,
    input  logic [NB-1:0] br_ready
);
    logic [NB-1:0] taken_q;
    logic [NB-1:0] done;
    logic          src_fire;

    always_comb begin
        done      = taken_q | br_ready;
        src_ready = &done;
        src_fire  = tfm_pkg::hs_fire(src_valid, src_ready);
    end

    for (genvar i = 0; i < NB; i++) begin : g_br
        assign br_valid[i] = src_valid & ~taken_q[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                taken_q[i] <= 1'b0;
            end else if (src_fire) begin
                taken_q[i] <= 1'b0;
            end else if (tfm_pkg::hs_fire(br_valid[i], br_ready[i])) begin
                taken_q[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tfm_stage.sv
module tfm_stage #(
    parameter int unsigned          DW   = tfm_pkg::FIELD_W_DEF,
    parameter tfm_pkg::stage_kind_e KIND = tfm_pkg::STG_COMB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] i_data,
    input  logic          i_valid,
    output logic          i_ready,
    output logic [DW-1:0] o_data,
    output logic          o_valid,
    input  logic          o_ready
);
    logic [DW-1:0] dbl;

    assign dbl = {i_data[DW-2:0], 1'b0};

    if (KIND == tfm_pkg::STG_REG) begin : g_reg
        logic          full_q;
        logic [DW-1:0] data_q;

        assign i_ready = ~full_q | o_ready;
        assign o_valid = full_q;
        assign o_data  = data_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                full_q <= 1'b0;
                data_q <= '0;
            end else if (tfm_pkg::hs_fire(i_valid, i_ready)) begin
                full_q <= 1'b1;
                data_q <= dbl;
            end else if (tfm_pkg::hs_fire(full_q, o_ready)) begin
                full_q <= 1'b0;
            end
        end
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = clk ^ rst;
        assign i_ready = o_ready;
        assign o_valid = i_valid;
        assign o_data  = dbl;
    end
endmodule

// File: rtl/tfm_join.sv
module tfm_join #(
    parameter int unsigned NB = tfm_pkg::NUM_BR
) (
    input  logic [NB-1:0] br_valid,
    output logic [NB-1:0] br_ready,
    output logic          dst_valid,
    input  logic          dst_ready
);
    assign dst_valid = &br_valid;

    for (genvar i = 0; i < NB; i++) begin : g_rdy
        assign br_ready[i] = tfm_pkg::hs_fire(dst_valid, dst_ready);
    end
endmodule

// File: rtl/tuple_fmap_top.sv
module tuple_fmap_top #(
    parameter int unsigned          DW    = tfm_pkg::FIELD_W_DEF,
    parameter tfm_pkg::stage_kind_e KIND0 = tfm_pkg::STG_REG,
    parameter tfm_pkg::stage_kind_e KIND1 = tfm_pkg::STG_COMB
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2*DW-1:0] in_data,
    input  logic            in_valid,
    output logic            in_ready,
    output logic [2*DW-1:0] out_data,
    output logic            out_valid,
    input  logic            out_ready
);
    localparam int unsigned NB = tfm_pkg::NUM_BR;

    typedef struct packed {
        logic [DW-1:0] f1;
        logic [DW-1:0] f0;
    } rec_t;

    rec_t          in_rec;
    rec_t          out_rec;
    logic [NB-1:0] fk_valid, fk_ready;
    logic [NB-1:0] st_valid, st_ready;
    logic [DW-1:0] st_data [NB];

    assign in_rec   = rec_t'(in_data);
    assign out_data = out_rec;

    tfm_fork #(.NB(NB)) u_fork (
        .clk      (clk),
        .rst      (rst),
        .src_valid(in_valid),
        .src_ready(in_ready),
        .br_valid (fk_valid),
        .br_ready (fk_ready)
    );

    tfm_stage #(.DW(DW), .KIND(KIND0)) u_stage0 (
        .clk    (clk),
        .rst    (rst),
        .i_data (in_rec.f0),
        .i_valid(fk_valid[0]),
        .i_ready(fk_ready[0]),
        .o_data (st_data[0]),
        .o_valid(st_valid[0]),
        .o_ready(st_ready[0])
    );

    tfm_stage #(.DW(DW), .KIND(KIND1)) u_stage1 (
        .clk    (clk),
        .rst    (rst),
        .i_data (in_rec.f1),
        .i_valid(fk_valid[1]),
        .i_ready(fk_ready[1]),
        .o_data (st_data[1]),
        .o_valid(st_valid[1]),
        .o_ready(st_ready[1])
    );

    tfm_join #(.NB(NB)) u_join (
        .br_valid (st_valid),
        .br_ready (st_ready),
        .dst_valid(out_valid),
        .dst_ready(out_ready)
    );

    assign out_rec.f0 = st_data[0];
    assign out_rec.f1 = st_data[1];
endmodule

// File: rtl/tuple_fmap_chk.sv
module tuple_fmap_chk #(
    parameter int unsigned DW = tfm_pkg::FIELD_W_DEF
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic [2*DW-1:0] out_data,
    input logic            out_valid,
    input logic            out_ready
);
    logic       rst_q;
    logic [1:0] pend_q;
    logic       in_fire, out_fire;

    assign in_fire  = in_valid & in_ready;
    assign out_fire = out_valid & out_ready;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) pend_q <= '0;
        else     pend_q <= pend_q + {1'b0, in_fire} - {1'b0, out_fire};
    end

    // R3
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> !out_valid);

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R4
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        pend_q <= 2'd1);

    // R4
    no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
        out_fire |-> (pend_q != 2'd0 || in_fire));
endmodule

bind tuple_fmap_top tuple_fmap_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready)
);

// File: tb/tuple_fmap_top_test.sv
module tuple_fmap_top_test;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2*DW-1:0] in_data = '0;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [2*DW-1:0] out_data;
    logic            out_valid;
    logic            out_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [2*DW-1:0] exp_q[$];

    always #4 clk = ~clk;

    tuple_fmap_top uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready)
    );

    function automatic logic [2*DW-1:0] model(input logic [2*DW-1:0] r);
        logic [DW-1:0] lo, hi;
        lo = r[DW-1:0] << 1;
        hi = r[2*DW-1:DW] << 1;
        return {hi, lo};
    endfunction

    task automatic check(input string req, input logic [2*DW-1:0] act,
                         input logic [2*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        repeat (3) next_cycle();
        rst = 1'b0;
        #1;
        check("R3 out_valid after reset", 32'(out_valid), 32'd0);
        next_cycle();
    endtask

    task automatic t_latency();
        logic [2*DW-1:0] r;
        r = {16'h0100, 16'h0001};
        in_data = r; in_valid = 1'b1; out_ready = 1'b1;
        #1;
        check("R6 out_valid in presentation cycle", 32'(out_valid), 32'd0);
        next_cycle(); #1;
        check("R6 out_valid next cycle", 32'(out_valid), 32'd1);
        check("R6 in_ready with output", 32'(in_ready), 32'd1);
        check("R1 field layout", out_data, 32'h0200_0002);
        next_cycle();
        in_valid = 1'b0;
        next_cycle();
    endtask

    task automatic t_wrap();
        in_data = {16'hFFFF, 16'h8001}; in_valid = 1'b1; out_ready = 1'b1;
        next_cycle(); #1;
        check("R2 wrap valid", 32'(out_valid), 32'd1);
        check("R2 wrap value", out_data, {16'hFFFE, 16'h0002});
        next_cycle();
        in_valid = 1'b0;
        next_cycle();
    endtask

    task automatic t_stall();
        logic [2*DW-1:0] r;
        r = {16'h1234, 16'hABCD};
        in_data = r; in_valid = 1'b1; out_ready = 1'b0;
        next_cycle();
        for (int k = 0; k < 4; k++) begin
            #1;
            check("R5 valid held", 32'(out_valid), 32'd1);
            check("R5 data held", out_data, model(r));
            check("R7 in_ready low", 32'(in_ready), 32'd0);
            next_cycle();
        end
        out_ready = 1'b1;
        #1;
        check("R7 in_ready on release", 32'(in_ready), 32'd1);
        next_cycle();
        in_valid = 1'b0;
        #1;
        check("R4 no duplicate after stall", 32'(out_valid), 32'd0);
        next_cycle();
    endtask

    task automatic t_stream(input int n, input int gap_mod, input int stall_mod);
        int sent = 0, got = 0, cyc = 0, bad = 0;
        logic [DW-1:0] lo;
        exp_q.delete();
        in_valid = 1'b0;
        while (got < n && cyc < 2000) begin
            if (!in_valid && sent < n && (cyc % gap_mod) != 1) begin
                lo = 16'(sent * 16'h1357 + 16'h00F1);
                in_data = {lo ^ 16'hC3A5, lo};
                in_valid = 1'b1;
            end
            out_ready = (cyc % stall_mod) != 2;
            #1;
            if (in_valid && in_ready) exp_q.push_back(model(in_data));
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R4 unexpected output actual=%h expected=none", out_data);
                end else begin
                    check("R4 stream order/value", out_data, exp_q.pop_front());
                end
                got++;
            end
            if (in_valid && in_ready) begin
                sent++;
                next_cycle();
                in_valid = 1'b0;
            end else begin
                next_cycle();
            end
            cyc++;
        end
        repeat (3) begin
            #1;
            if (out_valid) bad++;
            next_cycle();
        end
        checks++;
        if (got != n || bad != 0 || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 stream count actual=%0d expected=%0d", got, n);
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_latency();
        t_wrap();
        t_stall();
        t_stream(20, 1000, 1000);
        t_stream(25, 3, 4);
        t_stream(30, 2, 3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule